// File: doc/BRIEF.md
# Dual-Field Capture Address Generator

This block sits behind a capture port that delivers one byte per valid cycle. The port treats the incoming stream as fields, and each field is a fixed number of lines of a fixed number of bytes. For every accepted byte the block produces one memory write slot. Each slot carries an address inside a two-half (ping-pong) buffer. Fields alternate between an odd-field base and an even-field base. Within a field, line starts are spaced by a programmable pitch. When a field's last byte is accepted, the block emits a field pulse that says which half has just been filled. It also says whether that half starts with the transport sync byte 0x47, so that downstream logic knows whether the half is worth handing on.

A protection limit guards the buffer. Any byte whose address reaches the limit is not written and raises a protection pulse instead. The in-field offset counts modulo 2^LIMIT_W, so a very long field restarts at its base. Configuration is staged: a shadow copy is loaded only on an upload strobe, and it becomes active at the next field start. Software can watch the address of the next byte, and it can read two sticky status bits that are cleared by writing ones.

Top module: `cap_field_dma`

## Requirements
- R1: After reset, no write, field or protection pulse is asserted, the status bits are 0 and the next-byte pointer is 0. The default active settings are: odd base 0, even base DEF_LINES*DEF_BYTES, protection limit 2*DEF_LINES*DEF_BYTES, pitch DEF_BYTES, geometry DEF_LINES x DEF_BYTES.
- R2: A byte accepted at a clock edge produces a write slot in the cycle after that edge. The slot carries the byte on wr_data and base + ((line*pitch + column) mod 2^LIMIT_W) on wr_addr. A cycle with no accepted byte produces no slot and no pulse in the following cycle.
- R3: cfg_geom bits [31:16] give the lines per field and bits [15:0] give the bytes per line. Both must be at least 1. A field completes after exactly lines*bytes accepted bytes.
- R4: The first field after reset is odd and uses the odd base (field_id 0). Fields then alternate. field_irq is a one-cycle pulse in the slot of a field's last byte, and field_id gives the half just finished.
- R5: With each field pulse, field_ok is 1 exactly when the first byte of that field was 0x47.
- R6: A byte whose address is at or above the protection limit gives a slot with wr_en low and a one-cycle prot_irq pulse instead. The position still advances.
- R7: When the in-field offset reaches 2^LIMIT_W, the address restarts at the field base.
- R8: Changes on the configuration inputs without cfg_upload have no effect. An upload is held in a shadow copy and applied at the next field start, or at once if no byte of the current field has been accepted yet.
- R9: cur_ptr shows the address that the next accepted byte would use.
- R10: sts bit 0 is set by a field pulse and bit 1 by a protection pulse. Writing a 1 in sts_clr clears the matching bit. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_data | input | 8 | Captured byte |
| cfg_upload | input | 1 | Load the configuration inputs into the shadow copy |
| cfg_base_odd | input | 32 | Odd-field base address |
| cfg_base_even | input | 32 | Even-field base address |
| cfg_prot | input | 32 | Protection limit (first forbidden address) |
| cfg_pitch | input | 16 | Address step between line starts |
| cfg_geom | input | 32 | Lines per field [31:16], bytes per line [15:0] |
| sts_clr | input | 2 | Write-one-to-clear for the sticky status bits |
| wr_en | output | 1 | Write slot with permitted address |
| wr_addr | output | 32 | Write address |
| wr_data | output | 8 | Write data |
| field_irq | output | 1 | Field-complete pulse |
| field_id | output | 1 | Half just completed (0 odd, 1 even) |
| field_ok | output | 1 | Completed field starts with 0x47 |
| prot_irq | output | 1 | Protection-violation pulse |
| cur_ptr | output | 32 | Address for the next byte |
| sts | output | 2 | Sticky status: bit 0 field, bit 1 protection |

## Verification
The last byte of a field can itself land on or beyond the protection limit. In that cycle the field pulse and the protection pulse must rise together, with no write. The bench provokes this with a limit that cuts the even half short and with random geometries, limits and uploads. A behavioural model that predicts every output on every clock then judges the result. A field completion that coincides with a status clear, and an upload that arrives exactly at a field boundary, are driven as well, and the same per-cycle comparison judges them.

// File: rtl/cap_pkg.sv
package cap_pkg;
    parameter int CAP_ADDR_W = 32;
    parameter int CAP_LEN_W  = 16;
    parameter int CAP_DATA_W = 8;
    parameter logic [CAP_DATA_W-1:0] CAP_SYNC = 8'h47;

    typedef struct packed {
        logic [CAP_ADDR_W-1:0] base_odd;
        logic [CAP_ADDR_W-1:0] base_even;
        logic [CAP_ADDR_W-1:0] prot;
        logic [CAP_LEN_W-1:0]  pitch;
        logic [CAP_LEN_W-1:0]  lines;
        logic [CAP_LEN_W-1:0]  bpl;
    } cap_cfg_t;
endpackage

// File: rtl/cap_cfg_bank.sv
module cap_cfg_bank
    import cap_pkg::*;
#(
    parameter int DEF_LINES = 2,
    parameter int DEF_BYTES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upload,
    input  cap_cfg_t new_cfg,
    input  logic     at_start,
    output cap_cfg_t eff
);
    localparam int A = CAP_ADDR_W;
    localparam int L = CAP_LEN_W;
    localparam int HALF = DEF_LINES * DEF_BYTES;

    localparam cap_cfg_t DEF_CFG = '{
        base_odd:  '0,
        base_even: A'(HALF),
        prot:      A'(2 * HALF),
        pitch:     L'(DEF_BYTES),
        lines:     L'(DEF_LINES),
        bpl:       L'(DEF_BYTES)
    };

    typedef struct packed {
        cap_cfg_t act;
        cap_cfg_t shd;
        logic     pend;
    } bank_t;

    bank_t    s_d, s_q;
    cap_cfg_t eff_c;

    always_comb begin
        s_d   = s_q;
        eff_c = (at_start && s_q.pend) ? s_q.shd : s_q.act;
        if (at_start) begin
            s_d.act  = eff_c;
            s_d.pend = 1'b0;
        end
        if (upload) begin
            s_d.shd  = new_cfg;
            s_d.pend = 1'b1;
        end
    end

    assign eff = eff_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{act: DEF_CFG, shd: DEF_CFG, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cap_walker.sv
module cap_walker
    import cap_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [CAP_DATA_W-1:0] in_data,
    input  cap_cfg_t              cfg,
    output logic                  at_start,
    output logic                  ev_field,
    output logic                  ev_prot,
    output logic                  wr_en,
    output logic [CAP_ADDR_W-1:0] wr_addr,
    output logic [CAP_DATA_W-1:0] wr_data,
    output logic                  field_id,
    output logic                  field_ok,
    output logic [CAP_ADDR_W-1:0] cur_ptr
);
    localparam int A = CAP_ADDR_W;
    localparam int L = CAP_LEN_W;
    localparam int D = CAP_DATA_W;

    typedef struct packed {
        logic               field;
        logic [L-1:0]       line;
        logic [L-1:0]       col;
        logic [LIMIT_W-1:0] lbase;
        logic [D-1:0]       first;
        logic               wr_en;
        logic [A-1:0]       wr_addr;
        logic [D-1:0]       wr_data;
        logic               fid;
        logic               fok;
    } walk_t;

    walk_t              s_d, s_q;
    logic [LIMIT_W-1:0] off;
    logic [A-1:0]       base;
    logic [A-1:0]       addr;
    logic [D-1:0]       sync_byte;
    logic               last_col;
    logic               last_line;
    logic               ev_field_c;
    logic               ev_prot_c;

    assign at_start = (s_q.line == '0) && (s_q.col == '0);

    always_comb begin
        s_d        = s_q;
        s_d.wr_en  = 1'b0;
        ev_field_c = 1'b0;
        ev_prot_c  = 1'b0;
        off        = s_q.lbase + LIMIT_W'(s_q.col);
        base       = s_q.field ? cfg.base_even : cfg.base_odd;
        addr       = base + A'(off);
        last_col   = (s_q.col == cfg.bpl - L'(1));
        last_line  = (s_q.line == cfg.lines - L'(1));
        sync_byte  = at_start ? in_data : s_q.first;
        if (in_valid) begin
            s_d.first   = sync_byte;
            s_d.wr_addr = addr;
            s_d.wr_data = in_data;
            if (addr < cfg.prot) begin
                s_d.wr_en = 1'b1;
            end else begin
                ev_prot_c = 1'b1;
            end
            if (last_col) begin
                s_d.col   = '0;
                s_d.lbase = s_q.lbase + LIMIT_W'(cfg.pitch);
                if (last_line) begin
                    s_d.line   = '0;
                    s_d.lbase  = '0;
                    s_d.field  = ~s_q.field;
                    s_d.fid    = s_q.field;
                    s_d.fok    = (sync_byte == CAP_SYNC);
                    ev_field_c = 1'b1;
                end else begin
                    s_d.line = s_q.line + L'(1);
                end
            end else begin
                s_d.col = s_q.col + L'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ev_field = ev_field_c;
    assign ev_prot  = ev_prot_c;
    assign wr_en    = s_q.wr_en;
    assign wr_addr  = s_q.wr_addr;
    assign wr_data  = s_q.wr_data;
    assign field_id = s_q.fid;
    assign field_ok = s_q.fok;
    assign cur_ptr  = addr;
endmodule

// File: rtl/cap_irq.sv
module cap_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_field,
    input  logic       ev_prot,
    input  logic [1:0] sts_clr,
    output logic       field_irq,
    output logic       prot_irq,
    output logic [1:0] sts
);
    typedef struct packed {
        logic       fi;
        logic       pi;
        logic [1:0] sts;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.fi  = ev_field;
        s_d.pi  = ev_prot;
        s_d.sts = (s_q.sts & ~sts_clr) | {ev_prot, ev_field};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign field_irq = s_q.fi;
    assign prot_irq  = s_q.pi;
    assign sts       = s_q.sts;
endmodule

// File: rtl/cap_field_dma.sv
module cap_field_dma
    import cap_pkg::*;
#(
    parameter int LIMIT_W   = 16,
    parameter int DEF_LINES = 2,
    parameter int DEF_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [CAP_DATA_W-1:0]   in_data,
    input  logic                    cfg_upload,
    input  logic [CAP_ADDR_W-1:0]   cfg_base_odd,
    input  logic [CAP_ADDR_W-1:0]   cfg_base_even,
    input  logic [CAP_ADDR_W-1:0]   cfg_prot,
    input  logic [CAP_LEN_W-1:0]    cfg_pitch,
    input  logic [2*CAP_LEN_W-1:0]  cfg_geom,
    input  logic [1:0]              sts_clr,
    output logic                    wr_en,
    output logic [CAP_ADDR_W-1:0]   wr_addr,
    output logic [CAP_DATA_W-1:0]   wr_data,
    output logic                    field_irq,
    output logic                    field_id,
    output logic                    field_ok,
    output logic                    prot_irq,
    output logic [CAP_ADDR_W-1:0]   cur_ptr,
    output logic [1:0]              sts
);
    localparam int L = CAP_LEN_W;

    cap_cfg_t new_cfg;
    cap_cfg_t eff;
    logic     at_start;
    logic     ev_field;
    logic     ev_prot;

    always_comb begin
        new_cfg.base_odd  = cfg_base_odd;
        new_cfg.base_even = cfg_base_even;
        new_cfg.prot      = cfg_prot;
        new_cfg.pitch     = cfg_pitch;
        new_cfg.lines     = cfg_geom[2*L-1:L];
        new_cfg.bpl       = cfg_geom[L-1:0];
    end

    cap_cfg_bank #(
        .DEF_LINES (DEF_LINES),
        .DEF_BYTES (DEF_BYTES)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upload   (cfg_upload),
        .new_cfg  (new_cfg),
        .at_start (at_start),
        .eff      (eff)
    );

    cap_walker #(
        .LIMIT_W (LIMIT_W)
    ) i_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cfg      (eff),
        .at_start (at_start),
        .ev_field (ev_field),
        .ev_prot  (ev_prot),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .field_id (field_id),
        .field_ok (field_ok),
        .cur_ptr  (cur_ptr)
    );

    cap_irq i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_field  (ev_field),
        .ev_prot   (ev_prot),
        .sts_clr   (sts_clr),
        .field_irq (field_irq),
        .prot_irq  (prot_irq),
        .sts       (sts)
    );
endmodule

// File: rtl/cap_field_dma_chk.sv
module cap_field_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       wr_en,
    input logic       prot_irq,
    input logic       field_irq,
    input logic       field_id,
    input logic [1:0] sts
);
    logic seen_q;
    logic last_id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            last_id_q <= 1'b0;
        end else if (field_irq) begin
            seen_q    <= 1'b1;
            last_id_q <= field_id;
        end
    end

    // R6: a slot is either a write or a protection hit, never both
    a_r6_write_or_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && prot_irq));

    // R4: consecutive field pulses report alternating halves
    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (field_irq && seen_q) |-> (field_id != last_id_q));

    // R4: the first field pulse after reset reports the odd half
    a_r4_first_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (field_irq && !seen_q) |-> (field_id == 1'b0));

    // R4: a field pulse comes with the slot of the last byte
    a_r4_pulse_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        field_irq |-> (wr_en || prot_irq));

    // R2: no accepted byte, no slot and no pulse
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!wr_en && !prot_irq && !field_irq));

    // R10: sticky bits rise only together with their pulse
    a_r10_field_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) |-> field_irq);

    a_r10_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prot_irq |-> sts[1]);
endmodule

bind cap_field_dma cap_field_dma_chk i_cap_field_dma_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wr_en     (wr_en),
    .prot_irq  (prot_irq),
    .field_irq (field_irq),
    .field_id  (field_id),
    .sts       (sts)
);

// File: tb/test_cap_field_dma.sv
module test_cap_field_dma;
    localparam int LIMIT_W = 8;
    localparam int LIM     = 1 << LIMIT_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        cfg_upload = 1'b0;
    logic [31:0] cfg_base_odd = '0;
    logic [31:0] cfg_base_even = '0;
    logic [31:0] cfg_prot = '0;
    logic [15:0] cfg_pitch = '0;
    logic [31:0] cfg_geom = '0;
    logic [1:0]  sts_clr = '0;
    logic        wr_en, field_irq, field_id, field_ok, prot_irq;
    logic [31:0] wr_addr, cur_ptr;
    logic [7:0]  wr_data;
    logic [1:0]  sts;

    always #10 clk = ~clk;

    cap_field_dma #(.LIMIT_W(LIMIT_W), .DEF_LINES(2), .DEF_BYTES(4)) i_cap_field_dma (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_upload(cfg_upload), .cfg_base_odd(cfg_base_odd),
        .cfg_base_even(cfg_base_even), .cfg_prot(cfg_prot), .cfg_pitch(cfg_pitch),
        .cfg_geom(cfg_geom), .sts_clr(sts_clr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .field_irq(field_irq), .field_id(field_id),
        .field_ok(field_ok), .prot_irq(prot_irq), .cur_ptr(cur_ptr), .sts(sts)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int unsigned a_bo, a_be, a_prot, a_pitch, a_lines, a_bpl;
    int unsigned s_bo, s_be, s_prot, s_pitch, s_lines, s_bpl;
    bit          m_pend, m_field;
    int unsigned m_line, m_col;
    logic [7:0]  m_first;
    logic        e_wr_en, e_fi, e_fid, e_fok, e_prot;
    logic [31:0] e_addr, e_ptr;
    logic [7:0]  e_data;
    logic [1:0]  e_sts;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        a_bo = 0; a_be = 8; a_prot = 16; a_pitch = 4; a_lines = 2; a_bpl = 4;
        s_bo = a_bo; s_be = a_be; s_prot = a_prot; s_pitch = a_pitch;
        s_lines = a_lines; s_bpl = a_bpl;
        m_pend = 0; m_field = 0; m_line = 0; m_col = 0; m_first = '0;
        e_wr_en = 0; e_fi = 0; e_fid = 0; e_fok = 0; e_prot = 0;
        e_addr = '0; e_data = '0; e_sts = '0; e_ptr = '0;
    endtask

    task automatic model_step(input logic v, input logic [7:0] d, input logic up,
                              input logic [1:0] clr);
        logic [31:0] b;
        int unsigned off;
        if (m_line == 0 && m_col == 0 && m_pend) begin
            a_bo = s_bo; a_be = s_be; a_prot = s_prot; a_pitch = s_pitch;
            a_lines = s_lines; a_bpl = s_bpl; m_pend = 0;
        end
        e_wr_en = 0; e_fi = 0; e_prot = 0;
        if (v) begin
            off = (m_line * a_pitch + m_col) % LIM;
            b = m_field ? a_be : a_bo;
            e_addr = b + off;
            e_data = d;
            if (m_line == 0 && m_col == 0) m_first = d;
            if (e_addr < a_prot) e_wr_en = 1; else e_prot = 1;
            if (m_col == a_bpl - 1) begin
                m_col = 0;
                if (m_line == a_lines - 1) begin
                    m_line = 0;
                    e_fi = 1; e_fid = m_field; e_fok = (m_first == 8'h47);
                    m_field = !m_field;
                end else m_line++;
            end else m_col++;
        end
        e_sts = (e_sts & ~clr) | {e_prot, e_fi};
        if (up) begin
            s_bo = cfg_base_odd; s_be = cfg_base_even; s_prot = cfg_prot;
            s_pitch = cfg_pitch; s_lines = cfg_geom[31:16]; s_bpl = cfg_geom[15:0];
            m_pend = 1;
        end
        if (m_line == 0 && m_col == 0) begin
            b = m_field ? (m_pend ? s_be : a_be) : (m_pend ? s_bo : a_bo);
            e_ptr = b;
        end else begin
            b = m_field ? a_be : a_bo;
            e_ptr = b + ((m_line * a_pitch + m_col) % LIM);
        end
    endtask

    task automatic compare_all();
        chk("R2 wr_en", 32'(wr_en), 32'(e_wr_en));
        chk("R2 wr_addr", wr_addr, e_addr);
        chk("R2 wr_data", 32'(wr_data), 32'(e_data));
        chk("R4 field_irq", 32'(field_irq), 32'(e_fi));
        chk("R4 field_id", 32'(field_id), 32'(e_fid));
        chk("R5 field_ok", 32'(field_ok), 32'(e_fok));
        chk("R6 prot_irq", 32'(prot_irq), 32'(e_prot));
        chk("R9 cur_ptr", cur_ptr, e_ptr);
        chk("R10 sts", 32'(sts), 32'(e_sts));
    endtask

    int fi_seen, pi_seen, base_hits, model_hits;

    task automatic cycle(input logic v, input logic [7:0] d, input logic up,
                         input logic [1:0] clr);
        in_valid = v; in_data = d; cfg_upload = up; sts_clr = clr;
        model_step(v, d, up, clr);
        if (v && e_wr_en && e_addr == 32'd1000) model_hits++;
        @(posedge clk);
        @(negedge clk);
        if (field_irq) fi_seen++;
        if (prot_irq) pi_seen++;
        if (wr_en && wr_addr == 32'd1000) base_hits++;
        compare_all();
    endtask

    task automatic set_cfg(input int bo, input int be, input int pr, input int pt,
                           input int ln, input int bp);
        cfg_base_odd = bo; cfg_base_even = be; cfg_prot = pr;
        cfg_pitch = 16'(pt); cfg_geom = {16'(ln), 16'(bp)};
    endtask

    task automatic finish_field();
        while (!(m_line == 0 && m_col == 0)) cycle(1'b1, 8'h5a, 1'b0, 2'b00);
    endtask

    initial begin
        logic [31:0] held;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 pulses", 32'({field_irq, prot_irq}), 0);
        chk("R1 sts", 32'(sts), 0);
        chk("R1 cur_ptr", cur_ptr, 0);

        // default geometry, two fields, sync then non-sync, with gaps
        for (int i = 0; i < 16; i++) begin
            cycle(1'b1, (i == 0) ? 8'h47 : 8'(i), 1'b0, 2'b00);
            if (i % 3 == 1) cycle(1'b0, 8'h00, 1'b0, 2'b00);
        end
        cycle(1'b0, 8'h00, 1'b0, 2'b11);

        // R8: configuration inputs without upload do nothing
        set_cfg(500, 600, 900, 7, 3, 3);
        cycle(1'b1, 8'h47, 1'b0, 2'b00);
        held = cur_ptr;
        repeat (3) cycle(1'b0, 8'h00, 1'b0, 2'b00);
        chk("R8 no upload no change", cur_ptr, held);
        finish_field();

        // R8: upload mid-field waits for the field boundary
        cycle(1'b1, 8'h47, 1'b0, 2'b00);
        set_cfg(100, 200, 1000, 6, 3, 4);
        cycle(1'b1, 8'h01, 1'b1, 2'b00);
        finish_field();
        repeat (30) cycle(1'b1, 8'h33, 1'b0, 2'b00);
        finish_field();

        // R3 and R5: 3 lines of 5 bytes, two fields, set-wins on clear (R10)
        set_cfg(0, 15, 1000, 5, 3, 5);
        cycle(1'b0, 8'h00, 1'b1, 2'b11);
        fi_seen = 0;
        for (int i = 0; i < 30; i++)
            cycle(1'b1, (i == 0) ? 8'h47 : (i == 15) ? 8'h11 : 8'(i), 1'b0,
                  (i == 14) ? 2'b01 : 2'b00);
        chk("R3 two fields of 15 bytes", 32'(fi_seen), 2);
        chk("R10 set wins over clear", 32'(sts[0]), 1);

        // R6: limit cuts even half (addresses 40..49, limit 45)
        set_cfg(0, 40, 45, 5, 2, 5);
        cycle(1'b0, 8'h00, 1'b1, 2'b11);
        finish_field();
        pi_seen = 0;
        for (int i = 0; i < 20; i++) cycle(1'b1, 8'(i), 1'b0, 2'b00);
        chk("R6 protection hits per pair", 32'(pi_seen), 5);
        cycle(1'b0, 8'h00, 1'b0, 2'b10);

        // R7: 400-byte field wraps at 256
        set_cfg(1000, 3000, 100000, 20, 20, 20);
        cycle(1'b0, 8'h00, 1'b1, 2'b00);
        base_hits = 0; model_hits = 0;
        for (int i = 0; i < 800; i++) cycle(1'b1, 8'(i), 1'b0, 2'b00);
        chk("R7 base revisited after wrap", 32'(base_hits), 32'(model_hits));
        chk("R7 wrap occurred", 32'(model_hits >= 2), 1);

        // random phase: uploads, gaps, clears, limits
        for (int i = 0; i < 1500; i++) begin
            if (i % 97 == 0)
                set_cfg($urandom % 64, 64 + $urandom % 64, $urandom % 160,
                        1 + $urandom % 6, 1 + $urandom % 4, 1 + $urandom % 4);
            cycle(($urandom % 4) != 0, 8'($urandom), (i % 97 == 0),
                  (($urandom % 8) == 0) ? 2'($urandom) : 2'b00);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule